// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets an on-chip master read and write an external asynchronous static RAM of 32K locations by 8 bits. The master places a request with a read/write select, a 15-bit address and, for writes, a data byte. The controller registers these, runs the memory strobes through a fixed sequence of clock cycles and returns a single-cycle completion pulse. On a read, the completion pulse comes with the byte fetched from the memory.

On the memory side the controller drives active-low select, output-enable and write-strobe lines and the address bus. For the shared 8-bit data bus it provides a separate outgoing byte, an incoming byte and a drive-enable, so the pad ring can build the bidirectional pin. Every timing minimum is a parameter in nanoseconds. The clock period is also a parameter, and each phase length is derived as the ceiling of the minimum divided by the period. With a 10 ns clock and the fast speed grade, a read takes 6 cycles and a write takes 6 cycles. The bus turnaround is timed so that the controller never drives the data bus while the memory may still be driving it.

Top module: `sram_ctl`

## Requirements
- R1: While `rst_n` is low at a clock edge, after that edge `sram_ce_n`, `sram_oe_n` and `sram_we_n` are all 1, `sram_drv` is 0 and `rsp_done` is 0.
- R2: A write holds `sram_ce_n` low for N_PRE + N_PWE consecutive cycles. `sram_we_n` is low only in the last N_PWE of them and rises on the same edge as `sram_ce_n`. N_PWE = max(ceil(tPWE/T), ceil(tSD/T)) and N_PRE = max(1, max(ceil(tWC/T), ceil(tAW/T)) - N_PWE), where T is the clock period. At the defaults (T=10, tWC=55, tAW=45, tPWE=40, tSD=25) these give 2 + 4 cycles.
- R3: `sram_oe_n` stays 1 throughout a write, and `sram_we_n` stays 1 throughout a read.
- R4: `sram_drv` is 1 only when `sram_oe_n` has been 1 for at least N_HZ = ceil(tHZOE/T) cycles (20 ns, 2 cycles at the defaults). It stays 1 from the first write cycle through the pulse and for one cycle after `sram_we_n` rises. It is never 1 during a read.
- R5: A read holds `sram_ce_n` and `sram_oe_n` low together for N_RD = max(ceil(tRC/T), ceil(tAA/T), ceil(tDOE/T)) cycles, 6 at the defaults. `sram_din` is captured on the last of these edges, and `rsp_rdata` shows the byte when `rsp_done` is 1.
- R6: `rsp_done` is a one-cycle pulse. A request sampled in idle gives `rsp_done` high in cycle N_PRE+N_PWE+1 after acceptance for a write, and in cycle N_RD+1 for a read, when no turnaround wait is needed.
- R7: The address, the write data and the direction are registered when a request is accepted. `sram_addr` and `sram_dout` do not change while the access runs, whatever the host inputs do.
- R8: `req` is ignored while an access is in progress. A request raised and dropped during an access starts no access of its own.
- R9: A byte written to any address is returned by a later read of that address, and other addresses are not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Access request, sampled only in idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read byte, valid with rsp_done |
| sram_ce_n | output | 1 | Memory select, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_addr | output | 15 | Memory address bus |
| sram_dout | output | 8 | Byte the controller puts on the data bus |
| sram_din | input | 8 | Byte read from the data bus |
| sram_drv | output | 1 | Controller drives the data bus when 1 |

## Verification
A wrong state or an off-by-one phase count shows at the memory pins within the access itself. The bench's memory model measures the strobe widths, the data and address setup times and the output-float time in nanoseconds at each write end and each drive-enable rise, so a short phase is flagged on the very edge where it occurs. If the read data is captured too early, the model is still returning filler bytes at that point, and the mismatch shows at the next `rsp_done`. A lost or stray state transition shows as a wrong completion latency or as a missing or corrupted byte on a later read-back.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the static RAM controller.
// Assumes all timing values are positive integers in nanoseconds.
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_WSET,
        ST_WPUL,
        ST_RACC,
        ST_DONE
    } ctl_state_t;

    // Ceiling division of a time by the clock period, at least one cycle.
    function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
// Down-counter that times one access phase.
// Loading V makes expired true after V further clock edges.
// Assumes load is not asserted together with a pending count that matters.
module sram_phase_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    // Load a new phase length, or count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_float_guard.sv
`timescale 1ns/1ps
// Counts the cycles for which the memory output enable has been high.
// This shows when the memory's data pins are certain to float.
// Assumes the bus is floated at reset (counter starts saturated).
module sram_float_guard #(
    parameter int N_HZ = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n,
    output logic float_ok,
    output logic float_soon
);
    localparam int CW = $clog2(N_HZ + 1) + 1;

    logic [CW-1:0] hi_cnt_q;

    // Restart on output enable low, saturate at N_HZ while it is high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_cnt_q <= CW'(N_HZ);
        else if (!oe_n)
            hi_cnt_q <= '0;
        else if (hi_cnt_q < CW'(N_HZ))
            hi_cnt_q <= hi_cnt_q + 1'b1;
    end

    assign float_ok   = (hi_cnt_q >= CW'(N_HZ));
    assign float_soon = float_ok || (oe_n && (hi_cnt_q == CW'(N_HZ - 1)));
endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
// Top of the static RAM controller: host request port plus strobe sequencer.
// It converts nanosecond minimums into cycle counts and drives the strobes
// straight from the registered state.
// Assumes the host keeps req low in idle unless it wants a new access.
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int AW      = 15,
    parameter int DW      = 8,
    parameter int CLK_NS  = 10,
    parameter int T_WC    = 55,
    parameter int T_AW    = 45,
    parameter int T_PWE   = 40,
    parameter int T_SD    = 25,
    parameter int T_RC    = 55,
    parameter int T_AA    = 55,
    parameter int T_DOE   = 25,
    parameter int T_HZOE  = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata,
    output logic          sram_ce_n,
    output logic          sram_oe_n,
    output logic          sram_we_n,
    output logic [AW-1:0] sram_addr,
    output logic [DW-1:0] sram_dout,
    input  logic [DW-1:0] sram_din,
    output logic          sram_drv
);
    localparam int N_PWE = imax(ns_to_cyc(T_PWE, CLK_NS), ns_to_cyc(T_SD, CLK_NS));
    localparam int N_WR  = imax(ns_to_cyc(T_WC, CLK_NS), ns_to_cyc(T_AW, CLK_NS));
    localparam int N_PRE = imax(1, N_WR - N_PWE);
    localparam int N_RD  = imax(ns_to_cyc(T_RC, CLK_NS),
                                imax(ns_to_cyc(T_AA, CLK_NS), ns_to_cyc(T_DOE, CLK_NS)));
    localparam int N_HZ  = ns_to_cyc(T_HZOE, CLK_NS);
    localparam int TW    = $clog2(imax(N_PRE, imax(N_PWE, N_RD)) + 1) + 1;

    ctl_state_t    state_q, state_d;
    logic          op_we_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_done;
    logic          float_ok;
    logic          float_soon;

    sram_phase_timer #(.TW(TW)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    sram_float_guard #(.N_HZ(N_HZ)) guard_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .oe_n       (sram_oe_n),
        .float_ok   (float_ok),
        .float_soon (float_soon)
    );

    // Next-state and phase-length selection.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: if (req) begin
                tmr_load = 1'b1;
                if (!req_we) begin
                    state_d = ST_RACC;
                    tmr_val = TW'(N_RD - 1);
                end else if (float_soon) begin
                    state_d = ST_WSET;
                    tmr_val = TW'(N_PRE - 1);
                end else begin
                    state_d = ST_TURN;
                end
            end
            ST_TURN: if (float_soon) begin
                state_d  = ST_WSET;
                tmr_load = 1'b1;
                tmr_val  = TW'(N_PRE - 1);
            end
            ST_WSET: if (tmr_done) begin
                state_d  = ST_WPUL;
                tmr_load = 1'b1;
                tmr_val  = TW'(N_PWE - 1);
            end
            ST_WPUL: if (tmr_done) state_d = ST_DONE;
            ST_RACC: if (tmr_done) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the request fields once, at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_we_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (state_q == ST_IDLE && req) begin
            op_we_q <= req_we;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Sample the read byte on the last edge of the read phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (state_q == ST_RACC && tmr_done)
            rdata_q <= sram_din;
    end

    // Strobes and bus control decoded from the state register.
    always_comb begin
        sram_ce_n = !(state_q inside {ST_WSET, ST_WPUL, ST_RACC});
        sram_we_n = (state_q != ST_WPUL);
        sram_oe_n = (state_q != ST_RACC);
        sram_drv  = (state_q inside {ST_WSET, ST_WPUL}) ||
                    (state_q == ST_DONE && op_we_q);
    end

    assign sram_addr = addr_q;
    assign sram_dout = wdata_q;
    assign rsp_done  = (state_q == ST_DONE);
    assign rsp_rdata = rdata_q;

    // Assertion support: length of the current write strobe.
    logic [TW:0] we_low_cnt;
    // Count cycles with the write strobe low.
    always_ff @(posedge clk) begin
        if (!rst_n)               we_low_cnt <= '0;
        else if (!sram_we_n)      we_low_cnt <= we_low_cnt + 1'b1;
        else                      we_low_cnt <= '0;
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (sram_ce_n && sram_oe_n && sram_we_n && !sram_drv && !rsp_done)); // R1
    AST_WE_IN_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> !sram_ce_n); // R2
    AST_WE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_low_cnt >= (TW+1)'(N_PWE))); // R2
    AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_oe_n); // R3
    AST_DRV_AFTER_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        sram_drv |-> (sram_oe_n && float_ok)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R6
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> ($stable(sram_addr) && $stable(sram_dout))); // R7
endmodule

// File: tb/sram_ctl_tb.sv
`timescale 1ns/1ps
// Directed bench with a timing-checking memory model.
module sram_ctl_tb_top;
    localparam int  TCK   = 10;
    localparam real T_PWE = 40.0, T_SD = 25.0, T_AW = 45.0, T_HZOE = 20.0;
    localparam real T_AA  = 55.0, T_DOE = 25.0;
    // Cycle counts from the requirements at the default parameters.
    localparam int N_PWE = 4, N_PRE = 2, N_RD = 6, N_HZ = 2;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req = 1'b0, req_we = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_done;
    logic [7:0]  rsp_rdata;
    logic        ce_n, oe_n, we_n, drv;
    logic [14:0] m_addr;
    logic [7:0]  m_dout;
    logic [7:0]  m_din = 8'hA5;

    int errors = 0, checks = 0;

    always #(TCK/2) clk = ~clk;

    sram_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .sram_ce_n(ce_n), .sram_oe_n(oe_n), .sram_we_n(we_n),
        .sram_addr(m_addr), .sram_dout(m_dout), .sram_din(m_din),
        .sram_drv(drv)
    );

    task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req_tag, act, exp, $realtime);
        end
    endtask

    // ---------------- behavioural memory model ----------------
    logic [7:0] mem [int];
    real t_ws = 0.0, t_data = 0.0, t_addr = 0.0, t_oe_fall = 0.0, t_oe_rise = -1000.0;
    wire wr_act = !ce_n && !we_n;

    function automatic logic [7:0] mem_rd(input int a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    always @(m_dout or drv) t_data = $realtime;
    always @(m_addr)        t_addr = $realtime;
    always @(negedge oe_n)  t_oe_fall = $realtime;
    always @(posedge oe_n)  t_oe_rise = $realtime;
    always @(posedge wr_act) t_ws = $realtime;

    // Write end: check pulse, setup times and store the byte.
    always @(negedge wr_act) begin
        chk($realtime - t_ws >= T_PWE, "R2 write pulse ns", int'($realtime - t_ws), int'(T_PWE));
        chk($realtime - t_data >= T_SD, "R4 data setup ns", int'($realtime - t_data), int'(T_SD));
        chk($realtime - t_addr >= T_AW, "R2 addr setup ns", int'($realtime - t_addr), int'(T_AW));
        chk(drv === 1'b1, "R4 drive at write end", drv, 1);
        mem[int'(m_addr)] = m_dout;
    end

    // Drive must not start before the memory outputs have floated.
    always @(posedge drv)
        chk($realtime - t_oe_rise >= T_HZOE, "R4 float before drive",
            int'($realtime - t_oe_rise), int'(T_HZOE));

    // Read path: data valid only after access times; also detect contention.
    always @(negedge clk) begin
        real ahead;
        ahead = $realtime + TCK/2;
        if (!ce_n && !oe_n && we_n) begin
            if (drv) chk(1'b0, "R4 bus contention", 1, 0);
            m_din <= (ahead - t_oe_fall >= T_DOE && ahead - t_addr >= T_AA) ?
                     mem_rd(int'(m_addr)) : 8'hA5;
        end else begin
            m_din <= 8'hA5;
        end
    end

    // ---------------- host access with waveform counting ----------------
    int c_ce, c_we, c_oe, c_drv, lat, bad_dir;
    logic [7:0] got;

    task automatic access(input bit we, input logic [14:0] a, input logic [7:0] d,
                          input bit poke);
        c_ce = 0; c_we = 0; c_oe = 0; c_drv = 0; lat = 0; bad_dir = 0;
        @(negedge clk);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        forever begin
            @(negedge clk);
            lat++;
            if (lat == 1) req = 1'b0;
            if (poke && lat == 2) begin
                req = 1'b1; req_we = 1'b1; req_addr = a ^ 15'h0101; req_wdata = ~d;
            end
            if (poke && lat == 3) req = 1'b0;
            if (!ce_n) c_ce++;
            if (!we_n) c_we++;
            if (!oe_n) c_oe++;
            if (drv)   c_drv++;
            if (we ? !oe_n : !we_n) bad_dir++;
            if (rsp_done === 1'b1 || lat > 50) break;
        end
        got = rsp_rdata;
        @(negedge clk);
        chk(rsp_done === 1'b0, "R6 done one cycle", rsp_done, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(ce_n === 1 && oe_n === 1 && we_n === 1, "R1 strobes high", {ce_n, oe_n, we_n}, 7);
        chk(drv === 0 && rsp_done === 0, "R1 drive and done low", {drv, rsp_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_write_shape();
        access(1'b1, 15'h1234, 8'h5A, 1'b0);
        chk(c_ce == N_PRE + N_PWE, "R2 select cycles", c_ce, N_PRE + N_PWE);
        chk(c_we == N_PWE, "R2 strobe cycles", c_we, N_PWE);
        chk(bad_dir == 0 && c_oe == 0, "R3 oe high in write", c_oe, 0);
        chk(c_drv == N_PRE + N_PWE + 1, "R4 drive span", c_drv, N_PRE + N_PWE + 1);
        chk(lat == N_PRE + N_PWE + 1, "R6 write latency", lat, N_PRE + N_PWE + 1);
    endtask

    task automatic t_read_shape();
        access(1'b0, 15'h1234, 8'h00, 1'b0);
        chk(c_ce == N_RD && c_oe == N_RD, "R5 read strobe cycles", c_oe, N_RD);
        chk(bad_dir == 0 && c_we == 0, "R3 we high in read", c_we, 0);
        chk(c_drv == 0, "R4 no drive in read", c_drv, 0);
        chk(lat == N_RD + 1, "R6 read latency", lat, N_RD + 1);
        chk(got == 8'h5A, "R5 read data", got, 8'h5A);
    endtask

    task automatic t_turnaround();
        access(1'b0, 15'h1234, 8'h00, 1'b0);
        access(1'b1, 15'h7FFF, 8'hC3, 1'b0);
        chk(lat >= N_PRE + N_PWE + 1, "R4 turnaround write latency", lat, N_PRE + N_PWE + 1);
        access(1'b0, 15'h7FFF, 8'h00, 1'b0);
        chk(got == 8'hC3, "R9 top address", got, 8'hC3);
    endtask

    task automatic t_hold_and_busy();
        access(1'b1, 15'h0222, 8'h11, 1'b0);
        access(1'b1, 15'h0323, 8'h22, 1'b0);
        access(1'b1, 15'h0222, 8'h99, 1'b1);
        chk(lat == N_PRE + N_PWE + 1, "R8 poke adds no access", lat, N_PRE + N_PWE + 1);
        repeat (12) @(negedge clk);
        chk(ce_n === 1'b1, "R8 no access after poke", ce_n, 1);
        access(1'b0, 15'h0222, 8'h00, 1'b0);
        chk(got == 8'h99, "R7 captured fields", got, 8'h99);
        access(1'b0, 15'h0323, 8'h00, 1'b0);
        chk(got == 8'h22, "R8 poked address untouched", got, 8'h22);
    endtask

    task automatic t_random();
        logic [14:0] adr [16];
        logic [7:0]  dat [16];
        for (int i = 0; i < 16; i++) begin
            adr[i] = 15'($urandom_range(0, 32767));
            adr[i][14:11] = 4'(i);
            dat[i] = 8'($urandom_range(0, 255));
            access(1'b1, adr[i], dat[i], 1'b0);
        end
        for (int i = 0; i < 16; i++) begin
            access(1'b0, adr[i], 8'h00, 1'b0);
            chk(got == dat[i], "R9 random readback", got, dat[i]);
        end
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_write_shape();
                t_read_shape();
                t_turnaround();
                t_hold_and_busy();
                t_random();
            end
            begin
                repeat (20000) @(posedge clk);
                chk(1'b0, "watchdog", 0, 1);
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule